// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the hardware side of entering an interrupt or exception handler in a simple 32-bit processor model. A single-cycle start pulse presents a request: the event kind (exception, external interrupt or software interrupt), an 8-bit vector, an optional error code, and the gate fields (target code selector, target offset, gate kind, target privilege level). The current machine state also comes in: the privilege level, flags, code selector, instruction pointer and stack pointer.

When the request is accepted and the handler runs at the current privilege level or a less privileged one, the block latches the context. It then writes the frame to a word-addressed stack port, one 32-bit word per cycle. The frame is the flags, then the code selector zero-extended to 32 bits, then the instruction pointer, then the error code if the vector defines one. Before each word the stack pointer moves down by four bytes, and the word goes to the new address. A one-cycle done pulse follows the last write. In that cycle the block presents the new code selector, instruction pointer, flags and stack pointer. A handler at a more privileged level is reported on a stack-switch request pulse and nothing is pushed. A reserved vector is reported on an error pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: While and right after reset, busy, done, switch_req, vec_err and stk_we are all low.
- R2: An accepted request writes flags, then {16'h0, cs}, then eip, to addresses sp-4, sp-8 and sp-12. The writes fall in the three cycles that follow the start cycle, one word per cycle with stk_we high.
- R3: Vectors 8, 10, 11, 12, 13, 14 and 17 add a fourth write of the error code at sp-16. All other vectors write exactly three words.
- R4: done is high for exactly one cycle, the cycle after the last write. In that cycle new_cs equals the gate selector, new_eip equals the gate offset and new_sp equals the address of the last write.
- R5: With gate_trap = 0 (interrupt gate), new_flags is cur_flags with bit 9 cleared. With gate_trap = 1 (trap gate), new_flags equals cur_flags.
- R6: req_kind encodes 0 = exception, 1 = external, 2 = software, and 3 is handled like an exception. An external request is ignored (no busy, no writes) while cur_flags bit 9 is 0. Exceptions and software requests are accepted whatever bit 9 holds.
- R7: If gate_dpl < cur_cpl (numerically lower means more privileged), switch_req pulses high for one cycle after the start cycle. There are no writes, no busy and no done.
- R8: Vectors 15 and 20 to 31 make vec_err pulse for one cycle after the start cycle, with no writes. This check takes precedence over R6 and R7.
- R9: A start pulse while busy is ignored. The frame and the final outputs belong to the first request.
- R10: busy is high from the cycle after an accepted start through the done cycle, and is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| req_kind | input | 2 | Event kind: 0 exception, 1 external, 2 software |
| req_vec | input | 8 | Vector number |
| req_code | input | 32 | Error code word |
| gate_sel | input | 16 | Handler code selector |
| gate_off | input | 32 | Handler entry offset |
| gate_trap | input | 1 | 1 = trap gate, 0 = interrupt gate |
| gate_dpl | input | 2 | Handler privilege level |
| cur_cpl | input | 2 | Current privilege level |
| cur_flags | input | 32 | Current flags word, bit 9 = interrupt enable |
| cur_cs | input | 16 | Current code selector |
| cur_eip | input | 32 | Current instruction pointer |
| cur_sp | input | 32 | Current stack pointer (byte address) |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle completion pulse |
| switch_req | output | 1 | Stack switch needed, nothing pushed |
| vec_err | output | 1 | Reserved vector requested |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 32 | Stack write byte address |
| stk_wdata | output | 32 | Stack write data |
| new_cs | output | 16 | Code selector after entry |
| new_eip | output | 32 | Instruction pointer after entry |
| new_flags | output | 32 | Flags after entry |
| new_sp | output | 32 | Stack pointer after entry |

## Verification
Several properties are checked on every cycle. Stack writes occur only while busy, and consecutive writes step down by exactly four bytes. done is a single pulse that directly follows a write and reports that write's address as the new stack pointer. An interrupt-gate entry always ends with the enable bit clear. Stack-switch and reserved-vector reports never coincide with activity, and busy cannot drop before done. Other behaviours need the bench's scenarios: the exact word order and contents, which vectors carry an error code, masking of external requests by the flags, the precedence among rejections, and a second start being ignored mid-entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SEL_W   = 16;
    localparam int unsigned VEC_W   = 8;
    localparam int unsigned PL_W    = 2;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned IF_BIT  = 9;

    typedef enum logic [1:0] {
        SRC_EXC = 2'd0,
        SRC_EXT = 2'd1,
        SRC_SW  = 2'd2,
        SRC_ALT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } st_e;

    typedef enum logic [1:0] {
        VD_RUN    = 2'd0,
        VD_DROP   = 2'd1,
        VD_SWITCH = 2'd2,
        VD_BADVEC = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [SEL_W-1:0]  cs;
        logic [WORD_W-1:0] eip;
        logic [WORD_W-1:0] code;
        logic [WORD_W-1:0] sp;
        logic [SEL_W-1:0]  gsel;
        logic [WORD_W-1:0] goff;
        logic              has_code;
        logic              trap;
    } ctx_t;

    function automatic logic vec_has_code(input logic [VEC_W-1:0] v);
        return (v == VEC_W'(8)) ||
               ((v >= VEC_W'(10)) && (v <= VEC_W'(14))) ||
               (v == VEC_W'(17));
    endfunction

    function automatic logic vec_is_reserved(input logic [VEC_W-1:0] v);
        return (v == VEC_W'(15)) ||
               ((v >= VEC_W'(20)) && (v <= VEC_W'(31)));
    endfunction

endpackage

// File: rtl/irq_entry_decode.sv
module irq_entry_decode
    import irq_entry_pkg::*;
(
    input  src_e             kind,
    input  logic [VEC_W-1:0] vec,
    input  logic             if_en,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  dpl,
    output verdict_e         verdict,
    output logic             has_code
);

    always_comb begin
        has_code = vec_has_code(vec);
        if (vec_is_reserved(vec)) begin
            verdict = VD_BADVEC;
        end else if ((kind == SRC_EXT) && !if_en) begin
            verdict = VD_DROP;
        end else if (dpl < cpl) begin
            verdict = VD_SWITCH;
        end else begin
            verdict = VD_RUN;
        end
    end

endmodule

// File: rtl/irq_entry_frame.sv
module irq_entry_frame
    import irq_entry_pkg::*;
#(
    parameter int unsigned BYTES = WORD_W / 8
) (
    input  ctx_t              ctx,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] addr,
    output logic [WORD_W-1:0] data
);

    logic [WORD_W-1:0] step;

    always_comb begin
        step = WORD_W'((int'(idx) + 1) * int'(BYTES));
        addr = ctx.sp - step;
        unique case (idx)
            IDX_W'(0): data = ctx.flags;
            IDX_W'(1): data = WORD_W'(ctx.cs);
            IDX_W'(2): data = ctx.eip;
            default:   data = ctx.code;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned IF_POS = IF_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        req_kind,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [WORD_W-1:0] req_code,
    input  logic [SEL_W-1:0]  gate_sel,
    input  logic [WORD_W-1:0] gate_off,
    input  logic              gate_trap,
    input  logic [PL_W-1:0]   gate_dpl,
    input  logic [PL_W-1:0]   cur_cpl,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_eip,
    input  logic [WORD_W-1:0] cur_sp,
    output logic              busy,
    output logic              done,
    output logic              switch_req,
    output logic              vec_err,
    output logic              stk_we,
    output logic [WORD_W-1:0] stk_addr,
    output logic [WORD_W-1:0] stk_wdata,
    output logic [SEL_W-1:0]  new_cs,
    output logic [WORD_W-1:0] new_eip,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_sp
);

    localparam int unsigned BYTES = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(2);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(3);

    st_e               st;
    ctx_t              ctx;
    logic [IDX_W-1:0]  idx;
    logic              sw_q;
    logic              bad_q;
    verdict_e          verdict;
    logic              dec_code;
    logic [WORD_W-1:0] f_addr;
    logic [WORD_W-1:0] f_data;
    logic [IDX_W-1:0]  last_idx;

    irq_entry_decode u_dec (
        .kind     (src_e'(req_kind)),
        .vec      (req_vec),
        .if_en    (cur_flags[IF_POS]),
        .cpl      (cur_cpl),
        .dpl      (gate_dpl),
        .verdict  (verdict),
        .has_code (dec_code)
    );

    irq_entry_frame #(.BYTES(BYTES)) u_frm (
        .ctx  (ctx),
        .idx  (idx),
        .addr (f_addr),
        .data (f_data)
    );

    assign last_idx   = ctx.has_code ? LAST_LONG : LAST_SHORT;
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);
    assign stk_we     = (st == ST_PUSH);
    assign stk_addr   = f_addr;
    assign stk_wdata  = f_data;
    assign switch_req = sw_q;
    assign vec_err    = bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ctx       <= '0;
            idx       <= '0;
            sw_q      <= 1'b0;
            bad_q     <= 1'b0;
            new_cs    <= '0;
            new_eip   <= '0;
            new_flags <= '0;
            new_sp    <= '0;
        end else begin
            sw_q  <= 1'b0;
            bad_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        unique case (verdict)
                            VD_RUN: begin
                                ctx.flags    <= cur_flags;
                                ctx.cs       <= cur_cs;
                                ctx.eip      <= cur_eip;
                                ctx.code     <= req_code;
                                ctx.sp       <= cur_sp;
                                ctx.gsel     <= gate_sel;
                                ctx.goff     <= gate_off;
                                ctx.has_code <= dec_code;
                                ctx.trap     <= gate_trap;
                                idx          <= '0;
                                st           <= ST_PUSH;
                            end
                            VD_SWITCH: sw_q  <= 1'b1;
                            VD_BADVEC: bad_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_PUSH: begin
                    if (idx == last_idx) begin
                        st        <= ST_DONE;
                        new_cs    <= ctx.gsel;
                        new_eip   <= ctx.goff;
                        new_sp    <= f_addr;
                        new_flags <= ctx.trap ? ctx.flags
                                              : (ctx.flags & ~(WORD_W'(1) << IF_POS));
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: nothing is active in the cycle right after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !stk_we && !done && !switch_req && !vec_err));

    // R2: writes occur only inside an entry, stepping down one word at a time
    p_we_in_entry_r2: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> busy);
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - WORD_W'(BYTES)));

    // R4: done is a single pulse right after a write, reporting its address
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(stk_we) && !stk_we));
    p_done_sp_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (new_sp == $past(stk_addr)));

    // R5: interrupt-gate entry ends with the enable bit clear
    p_if_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !ctx.trap) |-> !new_flags[IF_POS]);

    // R7: a stack-switch report comes with no activity
    p_switch_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        switch_req |-> (!busy && !stk_we && !vec_err));

    // R8: a reserved-vector report comes with no activity
    p_badvec_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        vec_err |-> (!busy && !stk_we));

    // R10: busy stays up until done has been shown
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  req_kind;
    logic [7:0]  req_vec;
    logic [31:0] req_code;
    logic [15:0] gate_sel;
    logic [31:0] gate_off;
    logic        gate_trap;
    logic [1:0]  gate_dpl;
    logic [1:0]  cur_cpl;
    logic [31:0] cur_flags;
    logic [15:0] cur_cs;
    logic [31:0] cur_eip;
    logic [31:0] cur_sp;
    logic        busy, done, switch_req, vec_err, stk_we;
    logic [31:0] stk_addr, stk_wdata;
    logic [15:0] new_cs;
    logic [31:0] new_eip, new_flags, new_sp;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } wr_t;

    wr_t   exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .start(start), .req_kind(req_kind), .req_vec(req_vec),
        .req_code(req_code), .gate_sel(gate_sel), .gate_off(gate_off),
        .gate_trap(gate_trap), .gate_dpl(gate_dpl), .cur_cpl(cur_cpl),
        .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_eip(cur_eip), .cur_sp(cur_sp),
        .busy(busy), .done(done), .switch_req(switch_req), .vec_err(vec_err),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .new_cs(new_cs), .new_eip(new_eip), .new_flags(new_flags), .new_sp(new_sp)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: every write the design makes is matched against the scoreboard
    always @(negedge clk) begin
        if (!rst && stk_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R7/R8/R9", "unexpected stack write", stk_addr, 32'h0);
            end else begin
                wr_t   e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(stk_addr == e.addr, t, "write address", stk_addr, e.addr);
                chk(stk_wdata == e.data, t, "write data", stk_wdata, e.data);
            end
        end
    end

    function automatic bit ref_has_code(input logic [7:0] v);
        return (v == 8) || (v == 10) || (v == 11) || (v == 12) ||
               (v == 13) || (v == 14) || (v == 17);
    endfunction

    task automatic load(input logic [1:0] kind, input logic [7:0] vec,
                        input logic [31:0] flags, input bit trap,
                        input logic [1:0] dpl, input logic [1:0] cpl);
        req_kind  = kind;
        req_vec   = vec;
        req_code  = 32'hC0DE_0000 | 32'(vec);
        gate_sel  = 16'h0100 + 16'(vec);
        gate_off  = 32'h8000_0000 + (32'(vec) << 4);
        gate_trap = trap;
        gate_dpl  = dpl;
        cur_cpl   = cpl;
        cur_flags = flags;
        cur_cs    = 16'h0A00 + 16'(vec);
        cur_eip   = 32'h0040_0000 + 32'(vec);
        cur_sp    = 32'h0001_0000 - (32'(vec) << 6);
    endtask

    // Driver: accepted entry, expected writes pushed to the scoreboard
    task automatic run_entry(input logic [1:0] kind, input logic [7:0] vec,
                             input logic [31:0] flags, input bit trap,
                             input logic [1:0] dpl, input logic [1:0] cpl,
                             input bit poke);
        int          nw;
        logic [31:0] sp, e_flags, e_off;
        logic [15:0] e_sel;
        load(kind, vec, flags, trap, dpl, cpl);
        sp      = cur_sp;
        e_sel   = gate_sel;
        e_off   = gate_off;
        e_flags = trap ? flags : (flags & ~32'h0000_0200);
        nw      = ref_has_code(vec) ? 4 : 3;
        exp_q.push_back('{addr: sp - 4,  data: flags});                 tag_q.push_back("R2");
        exp_q.push_back('{addr: sp - 8,  data: {16'h0, cur_cs}});       tag_q.push_back("R2");
        exp_q.push_back('{addr: sp - 12, data: cur_eip});               tag_q.push_back("R2");
        if (nw == 4) begin
            exp_q.push_back('{addr: sp - 16, data: req_code});          tag_q.push_back("R3");
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
        if (poke) begin
            start    = 1'b1;
            req_vec  = 8'd3;
            gate_sel = 16'h7777;
            gate_off = 32'h7777_7777;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9", "busy during ignored start", 32'(busy), 32'd1);
            for (int i = 0; i < nw - 1; i++) @(negedge clk);
        end else begin
            for (int i = 0; i < nw; i++) @(negedge clk);
        end
        chk(done == 1'b1, "R4", "done after last write", 32'(done), 32'd1);
        chk(busy == 1'b1, "R10", "busy in done cycle", 32'(busy), 32'd1);
        chk(new_cs == e_sel, poke ? "R9" : "R4", "new_cs", 32'(new_cs), 32'(e_sel));
        chk(new_eip == e_off, poke ? "R9" : "R4", "new_eip", new_eip, e_off);
        chk(new_sp == sp - 32'(4 * nw), "R3", "new_sp", new_sp, sp - 32'(4 * nw));
        chk(new_flags == e_flags, "R5", "new_flags", new_flags, e_flags);
        chk(exp_q.size() == 0, "R3", "words left unwritten", 32'(exp_q.size()), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R4", "done is one cycle", 32'(done), 32'd0);
        chk(busy == 1'b0, "R10", "busy after done", 32'(busy), 32'd0);
    endtask

    // Driver: rejected request; the monitor flags any write
    task automatic run_reject(input logic [1:0] kind, input logic [7:0] vec,
                              input logic [31:0] flags, input logic [1:0] dpl,
                              input logic [1:0] cpl, input bit e_sw, input bit e_bad,
                              input string req);
        load(kind, vec, flags, 1'b0, dpl, cpl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(switch_req == e_sw, req, "switch_req", 32'(switch_req), 32'(e_sw));
        chk(vec_err == e_bad, req, "vec_err", 32'(vec_err), 32'(e_bad));
        chk(busy == 1'b0, req, "busy on reject", 32'(busy), 32'd0);
        @(negedge clk);
        chk(!switch_req && !vec_err && !busy && !done, req, "quiet after reject",
            {28'h0, switch_req, vec_err, busy, done}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        load(2'd0, 8'd0, 32'h0000_0202, 1'b0, 2'd0, 2'd0);
        repeat (4) @(negedge clk);
        chk({busy, done, switch_req, vec_err, stk_we} == 5'b0, "R1", "outputs in reset",
            32'({busy, done, switch_req, vec_err, stk_we}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, switch_req, vec_err, stk_we} == 5'b0, "R1", "outputs after reset",
            32'({busy, done, switch_req, vec_err, stk_we}), 32'd0);

        // R2 R5: exception, interrupt gate, three words, enable bit cleared
        run_entry(2'd0, 8'd0, 32'h0000_0246, 1'b0, 2'd0, 2'd0, 1'b0);
        // R3 R5: page fault through a trap gate, error code pushed, flags kept
        run_entry(2'd0, 8'd14, 32'h0000_0283, 1'b1, 2'd0, 2'd0, 1'b0);
        // R3: other code-carrying and non-code vectors
        run_entry(2'd0, 8'd8,  32'h0000_0002, 1'b0, 2'd0, 2'd0, 1'b0);
        run_entry(2'd0, 8'd10, 32'h0000_0202, 1'b1, 2'd0, 2'd0, 1'b0);
        run_entry(2'd0, 8'd17, 32'h0000_0202, 1'b0, 2'd1, 2'd1, 1'b0);
        run_entry(2'd0, 8'd9,  32'h0000_0202, 1'b0, 2'd0, 2'd0, 1'b0);
        run_entry(2'd3, 8'd16, 32'h0000_0202, 1'b0, 2'd0, 2'd0, 1'b0);
        run_entry(2'd0, 8'd18, 32'h0000_0200, 1'b1, 2'd0, 2'd0, 1'b0);
        // R6: external masked, then enabled; software ignores the mask
        run_reject(2'd1, 8'd40, 32'h0000_0002, 2'd0, 2'd0, 1'b0, 1'b0, "R6");
        run_entry(2'd1, 8'd40, 32'h0000_0202, 1'b0, 2'd0, 2'd0, 1'b0);
        run_entry(2'd2, 8'd128, 32'h0000_0002, 1'b1, 2'd3, 2'd3, 1'b0);
        run_entry(2'd0, 8'd13, 32'h0000_0002, 1'b0, 2'd0, 2'd0, 1'b0);
        // R7: more privileged handler needs a stack switch; less privileged does not
        run_reject(2'd0, 8'd6, 32'h0000_0202, 2'd0, 2'd3, 1'b1, 1'b0, "R7");
        run_reject(2'd1, 8'd33, 32'h0000_0202, 2'd1, 2'd2, 1'b1, 1'b0, "R7");
        run_entry(2'd0, 8'd6, 32'h0000_0202, 1'b0, 2'd3, 2'd0, 1'b0);
        // R8: reserved vectors, precedence over masking and switching
        run_reject(2'd0, 8'd15, 32'h0000_0202, 2'd0, 2'd0, 1'b0, 1'b1, "R8");
        run_reject(2'd0, 8'd20, 32'h0000_0202, 2'd0, 2'd0, 1'b0, 1'b1, "R8");
        run_reject(2'd1, 8'd31, 32'h0000_0002, 2'd0, 2'd3, 1'b0, 1'b1, "R8");
        run_reject(2'd2, 8'd25, 32'h0000_0202, 2'd0, 2'd3, 1'b0, 1'b1, "R8");
        // R9: a second start mid-entry is ignored
        run_entry(2'd0, 8'd11, 32'h0000_0202, 1'b0, 2'd0, 2'd0, 1'b1);
        run_entry(2'd2, 8'd64, 32'h0000_0202, 1'b1, 2'd0, 2'd0, 1'b1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        summary();
    end

endmodule